// File: doc/BRIEF.md
# Configuration access register bank

This block is a slave register bank through which a processor issues configuration cycles. One channel targets the host's own configuration space and the other targets devices on an external PCI-style bus. Software first programs an address register and a command/byte-enable register for the channel it wants. It then starts the cycle by writing that channel's write-data register, or by reading its read-data register. The block sends a one-shot request to a downstream request/response port. It stalls the register access until the response arrives, then completes the access with the returned data.

A failed downstream response sets sticky status flags: external failures go to a bus-side error log and local failures to a processor-side error log. The address of the first failing access is captured. Software clears a flag by writing a 1 to it, so writing back the value it just read clears exactly the flags that were set. The electrical bus protocol, arbitration and memory-window translation are outside this block.

Top module: `cfgb_bank`

## Requirements
- R1: After synchronous reset every register reads zero, `dn_req` is low, and `bus_ready` stays low while `bus_valid` is low.
- R2: The local control word at offset 0x00 keeps only the dword offset in bits 7:2, the direction in bit 16 (1 = write, 0 = read) and the byte enables in bits 23:20. All other bits read zero.
- R3: The external address at 0x0C keeps all 32 bits. The external control word at 0x10 keeps the bus command in bits 3:0 and the byte enables in bits 7:4, and all other bits read zero.
- R4: A write to 0x04 while bit 16 of the local control word is set stores the data. It raises `dn_req` for exactly one cycle with `dn_local`=1, `dn_write`=1, `dn_addr` = dword offset times 4, `dn_be` = bits 23:20, `dn_cmd`=0 and `dn_wdata` = the written word.
- R5: A read of 0x08 while bit 16 is clear issues a local read request. The access completes with the response data, which is also stored in the register at 0x08.
- R6: A write to 0x14 while the command field is 0xB issues an external write, with `dn_addr` = external address, `dn_be` = bits 7:4 and `dn_cmd` = 0xB.
- R7: A read of 0x18 while the command field is 0xA issues an external read. The access returns, and 0x18 stores, the response data, or all ones if the response reports an error.
- R8: A write to 0x04 or 0x14, or a read of 0x08 or 0x18, whose channel is not set up for that direction issues no request. It acts as a plain register access (the read-data registers return their stored value).
- R9: An external response error sets bit 0 (read) or bit 1 (write) of the status at 0x1C. The external address of that access is captured in 0x20.
- R10: A local response error sets bit 0 of the status at 0x24. The local dword offset times 4 is captured in 0x28.
- R11: Writing a 1 to a status bit clears it, writing 0 leaves it, and only a register write can clear a status bit.
- R12: While any bit of an error status is set, a new error sets its bit but leaves the captured address unchanged.
- R13: Offsets 0x2C and above, and offsets not a multiple of 4, read zero and ignore writes. Writes to 0x08, 0x18, 0x20 and 0x28 are ignored.
- R14: An access that starts no downstream request completes in the same cycle it is presented. A request's completion comes one cycle after the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access present; held until `bus_ready` |
| bus_we | input | 1 | 1 = register write, 0 = register read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Register write data |
| bus_ready | output | 1 | Access completes at this clock edge |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| dn_req | output | 1 | One-cycle configuration request |
| dn_local | output | 1 | 1 = host's own configuration space, 0 = external bus |
| dn_write | output | 1 | 1 = configuration write |
| dn_addr | output | 32 | Configuration address |
| dn_be | output | 4 | Byte enables |
| dn_cmd | output | 4 | Bus command (0 for local) |
| dn_wdata | output | 32 | Write data of the request |
| dn_rsp_valid | input | 1 | Response for the pending request |
| dn_rsp_data | input | 32 | Response read data |
| dn_rsp_err | input | 1 | Response reports a failed cycle |

## Verification
Suppose the sequencer's state goes wrong. A trigger access then issues a request twice or not at all, or stalls the register bus for the wrong number of cycles. This shows on `dn_req` and in the `bus_ready` wait count on the very access concerned. A corrupted control or data register shows up as wrong fields on the next request or in the next read-back of that offset. A wrong error log stays invisible until software reads 0x1C to 0x28, so the bench reads them at random points and again after every directed error case. Sticky flags and held addresses are also watched every cycle by properties.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

    localparam int WORD_W  = 32;
    localparam int LOFS_W  = 8;            // byte width of the local configuration space
    localparam int LDW_W   = LOFS_W - 2;   // dword index width
    localparam int BE_W    = 4;
    localparam int CMD_W   = 4;
    localparam int LWR_BIT = 16;
    localparam int LBE_LSB = 20;
    localparam int EBE_LSB = 4;
    localparam int BERR_W  = 2;
    localparam int PERR_W  = 1;

    localparam logic [CMD_W-1:0] CMD_CFG_RD = 4'hA;
    localparam logic [CMD_W-1:0] CMD_CFG_WR = 4'hB;

    typedef enum logic [3:0] {
        SEL_LCTL, SEL_LWD, SEL_LRD,
        SEL_EADR, SEL_ECTL, SEL_EWD, SEL_ERD,
        SEL_BERR, SEL_BADR, SEL_PERR, SEL_PADR,
        SEL_NONE
    } reg_sel_e;

    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DONE} seq_st_e;

    typedef struct packed {
        logic [BE_W-1:0]  be;
        logic             wr;
        logic [LDW_W-1:0] dword;
    } lctl_t;

    typedef struct packed {
        logic [BE_W-1:0]  be;
        logic [CMD_W-1:0] cmd;
    } ectl_t;

    function automatic reg_sel_e decode(input logic [WORD_W-1:0] ofs);
        case (ofs)
            32'h00:  return SEL_LCTL;
            32'h04:  return SEL_LWD;
            32'h08:  return SEL_LRD;
            32'h0C:  return SEL_EADR;
            32'h10:  return SEL_ECTL;
            32'h14:  return SEL_EWD;
            32'h18:  return SEL_ERD;
            32'h1C:  return SEL_BERR;
            32'h20:  return SEL_BADR;
            32'h24:  return SEL_PERR;
            32'h28:  return SEL_PADR;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] pack_lctl(input lctl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[LDW_W+1:2]               = c.dword;
        w[LWR_BIT]                 = c.wr;
        w[LBE_LSB+BE_W-1:LBE_LSB]  = c.be;
        return w;
    endfunction

    function automatic lctl_t unpack_lctl(input logic [WORD_W-1:0] w);
        lctl_t c;
        c.dword = w[LDW_W+1:2];
        c.wr    = w[LWR_BIT];
        c.be    = w[LBE_LSB+BE_W-1:LBE_LSB];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_ectl(input ectl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CMD_W-1:0]              = c.cmd;
        w[EBE_LSB+BE_W-1:EBE_LSB] = c.be;
        return w;
    endfunction

    function automatic ectl_t unpack_ectl(input logic [WORD_W-1:0] w);
        ectl_t c;
        c.cmd = w[CMD_W-1:0];
        c.be  = w[EBE_LSB+BE_W-1:EBE_LSB];
        return c;
    endfunction

endpackage

// File: rtl/cfgb_ctlregs.sv
module cfgb_ctlregs
    import cfgb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [WORD_W-1:0] wdata,
    output lctl_t             lctl,
    output logic [WORD_W-1:0] lwd,
    output logic [WORD_W-1:0] eadr,
    output ectl_t             ectl,
    output logic [WORD_W-1:0] ewd
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lctl <= '0;
            lwd  <= '0;
            eadr <= '0;
            ectl <= '0;
            ewd  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_LCTL: lctl <= unpack_lctl(wdata);
                SEL_LWD:  lwd  <= wdata;
                SEL_EADR: eadr <= wdata;
                SEL_ECTL: ectl <= unpack_ectl(wdata);
                SEL_EWD:  ewd  <= wdata;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/cfgb_errlog.sv
module cfgb_errlog
    import cfgb_pkg::*;
#(
    parameter int NB = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NB-1:0]     set,
    input  logic [WORD_W-1:0] set_addr,
    input  logic              clr_en,
    input  logic [NB-1:0]     clr,
    output logic [NB-1:0]     status,
    output logic [WORD_W-1:0] addr
);

    logic [NB-1:0] clr_mask;
    logic          first;

    always_comb begin
        clr_mask = clr_en ? clr : '0;
        first    = (status == '0) && (set != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            addr   <= '0;
        end else begin
            status <= (status & ~clr_mask) | set;
            if (first) addr <= set_addr;
        end
    end

endmodule

// File: rtl/cfgb_seq.sv
module cfgb_seq
    import cfgb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  reg_sel_e          sel,
    input  logic [WORD_W-1:0] bus_wdata,
    input  lctl_t             lctl,
    input  logic [WORD_W-1:0] eadr,
    input  ectl_t             ectl,
    input  logic              dn_rsp_valid,
    input  logic [WORD_W-1:0] dn_rsp_data,
    input  logic              dn_rsp_err,
    output seq_st_e           st,
    output logic              ready,
    output logic [WORD_W-1:0] done_rdata,
    output logic [WORD_W-1:0] lrd,
    output logic [WORD_W-1:0] erd,
    output logic              dn_req,
    output logic              dn_local,
    output logic              dn_write,
    output logic [WORD_W-1:0] dn_addr,
    output logic [BE_W-1:0]   dn_be,
    output logic [CMD_W-1:0]  dn_cmd,
    output logic [WORD_W-1:0] dn_wdata,
    output logic              lerr_set,
    output logic [BERR_W-1:0] berr_set
);

    logic              trig_lw, trig_lr, trig_ew, trig_er, trig, trig_loc;
    logic              rsp_fire;
    logic [WORD_W-1:0] rd_val;

    always_comb begin
        trig_lw  = bus_we  && (sel == SEL_LWD) &&  lctl.wr;
        trig_lr  = !bus_we && (sel == SEL_LRD) && !lctl.wr;
        trig_ew  = bus_we  && (sel == SEL_EWD) && (ectl.cmd == CMD_CFG_WR);
        trig_er  = !bus_we && (sel == SEL_ERD) && (ectl.cmd == CMD_CFG_RD);
        trig     = trig_lw || trig_lr || trig_ew || trig_er;
        trig_loc = trig_lw || trig_lr;
        ready    = (st == ST_DONE) || ((st == ST_IDLE) && bus_valid && !trig);
        rsp_fire = (st == ST_WAIT) && dn_rsp_valid;
        rd_val   = (!dn_local && dn_rsp_err) ? '1 : dn_rsp_data;
        lerr_set = rsp_fire && dn_rsp_err && dn_local;
        berr_set = '0;
        if (rsp_fire && dn_rsp_err && !dn_local)
            berr_set = dn_write ? 2'b10 : 2'b01;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            dn_req     <= 1'b0;
            dn_local   <= 1'b0;
            dn_write   <= 1'b0;
            dn_addr    <= '0;
            dn_be      <= '0;
            dn_cmd     <= '0;
            dn_wdata   <= '0;
            done_rdata <= '0;
            lrd        <= '0;
            erd        <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (bus_valid && trig) begin
                        st       <= ST_WAIT;
                        dn_req   <= 1'b1;
                        dn_local <= trig_loc;
                        dn_write <= bus_we;
                        dn_addr  <= trig_loc ? WORD_W'({lctl.dword, 2'b00}) : eadr;
                        dn_be    <= trig_loc ? lctl.be : ectl.be;
                        dn_cmd   <= trig_loc ? '0 : ectl.cmd;
                        dn_wdata <= bus_we ? bus_wdata : '0;
                    end
                end
                ST_WAIT: begin
                    dn_req <= 1'b0;
                    if (dn_rsp_valid) begin
                        st         <= ST_DONE;
                        done_rdata <= dn_write ? '0 : rd_val;
                        if (!dn_write) begin
                            if (dn_local) lrd <= rd_val;
                            else          erd <= rd_val;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cfgb_bank.sv
module cfgb_bank
    import cfgb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ready,
    output logic [31:0]       bus_rdata,
    output logic              dn_req,
    output logic              dn_local,
    output logic              dn_write,
    output logic [31:0]       dn_addr,
    output logic [3:0]        dn_be,
    output logic [3:0]        dn_cmd,
    output logic [31:0]       dn_wdata,
    input  logic              dn_rsp_valid,
    input  logic [31:0]       dn_rsp_data,
    input  logic              dn_rsp_err
);

    reg_sel_e          sel;
    seq_st_e           st;
    lctl_t             lctl;
    ectl_t             ectl;
    logic [WORD_W-1:0] lwd, eadr, ewd, lrd, erd, done_rdata;
    logic [WORD_W-1:0] badr, padr, mux_rdata;
    logic [BERR_W-1:0] bst, berr_set;
    logic [PERR_W-1:0] pst;
    logic              lerr_set, reg_we;

    always_comb begin
        sel    = decode(WORD_W'(bus_addr));
        reg_we = (st == ST_IDLE) && bus_valid && bus_we;
    end

    cfgb_ctlregs u_ctl (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_we),
        .sel   (sel),
        .wdata (bus_wdata),
        .lctl  (lctl),
        .lwd   (lwd),
        .eadr  (eadr),
        .ectl  (ectl),
        .ewd   (ewd)
    );

    cfgb_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .bus_valid    (bus_valid),
        .bus_we       (bus_we),
        .sel          (sel),
        .bus_wdata    (bus_wdata),
        .lctl         (lctl),
        .eadr         (eadr),
        .ectl         (ectl),
        .dn_rsp_valid (dn_rsp_valid),
        .dn_rsp_data  (dn_rsp_data),
        .dn_rsp_err   (dn_rsp_err),
        .st           (st),
        .ready        (bus_ready),
        .done_rdata   (done_rdata),
        .lrd          (lrd),
        .erd          (erd),
        .dn_req       (dn_req),
        .dn_local     (dn_local),
        .dn_write     (dn_write),
        .dn_addr      (dn_addr),
        .dn_be        (dn_be),
        .dn_cmd       (dn_cmd),
        .dn_wdata     (dn_wdata),
        .lerr_set     (lerr_set),
        .berr_set     (berr_set)
    );

    cfgb_errlog #(.NB(BERR_W)) u_berr (
        .clk      (clk),
        .rst      (rst),
        .set      (berr_set),
        .set_addr (dn_addr),
        .clr_en   (reg_we && (sel == SEL_BERR)),
        .clr      (bus_wdata[BERR_W-1:0]),
        .status   (bst),
        .addr     (badr)
    );

    cfgb_errlog #(.NB(PERR_W)) u_perr (
        .clk      (clk),
        .rst      (rst),
        .set      (lerr_set),
        .set_addr (dn_addr),
        .clr_en   (reg_we && (sel == SEL_PERR)),
        .clr      (bus_wdata[PERR_W-1:0]),
        .status   (pst),
        .addr     (padr)
    );

    always_comb begin
        case (sel)
            SEL_LCTL: mux_rdata = pack_lctl(lctl);
            SEL_LWD:  mux_rdata = lwd;
            SEL_LRD:  mux_rdata = lrd;
            SEL_EADR: mux_rdata = eadr;
            SEL_ECTL: mux_rdata = pack_ectl(ectl);
            SEL_EWD:  mux_rdata = ewd;
            SEL_ERD:  mux_rdata = erd;
            SEL_BERR: mux_rdata = WORD_W'(bst);
            SEL_BADR: mux_rdata = badr;
            SEL_PERR: mux_rdata = WORD_W'(pst);
            SEL_PADR: mux_rdata = padr;
            default:  mux_rdata = '0;
        endcase
        bus_rdata = (st == ST_DONE) ? done_rdata : mux_rdata;
    end

endmodule

// File: rtl/cfgb_checks.sv
module cfgb_checks
    import cfgb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic              bus_ready,
    input logic [31:0]       bus_rdata,
    input reg_sel_e          sel,
    input seq_st_e           st,
    input logic              dn_req,
    input logic              dn_local,
    input logic              dn_write,
    input logic              dn_rsp_valid,
    input logic              dn_rsp_err,
    input logic [31:0]       erd,
    input logic [BERR_W-1:0] bst,
    input logic [31:0]       badr,
    input logic [PERR_W-1:0] pst,
    input logic [31:0]       padr
);

    a_r1_no_req_after_reset: assert property (@(posedge clk)
        rst |=> !dn_req);

    a_r4_req_one_shot: assert property (@(posedge clk) disable iff (rst)
        dn_req |=> !dn_req);

    a_r7_err_read_all_ones: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && dn_rsp_valid && dn_rsp_err && !dn_local && !dn_write)
        |=> (erd == 32'hFFFF_FFFF));

    a_r11_perr_cleared_by_write: assert property (@(posedge clk) disable iff (rst)
        $fell(pst[0]) |-> $past(bus_valid && bus_we && sel == SEL_PERR && bus_wdata[0]));

    a_r11_berr_cleared_by_write: assert property (@(posedge clk) disable iff (rst)
        $fell(bst[1]) |-> $past(bus_valid && bus_we && sel == SEL_BERR && bus_wdata[1]));

    a_r12_padr_held: assert property (@(posedge clk) disable iff (rst)
        ($past(pst != '0) && pst != '0) |-> $stable(padr));

    a_r12_badr_held: assert property (@(posedge clk) disable iff (rst)
        ($past(bst != '0) && bst != '0) |-> $stable(badr));

    a_r13_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && bus_valid && !bus_we && sel == SEL_NONE) |-> (bus_ready && bus_rdata == '0));

    a_r14_plain_no_wait: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && bus_valid &&
         !(sel == SEL_LWD || sel == SEL_LRD || sel == SEL_EWD || sel == SEL_ERD)) |-> bus_ready);

endmodule

bind cfgb_bank cfgb_checks u_checks (
    .clk          (clk),
    .rst          (rst),
    .bus_valid    (bus_valid),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_ready    (bus_ready),
    .bus_rdata    (bus_rdata),
    .sel          (sel),
    .st           (st),
    .dn_req       (dn_req),
    .dn_local     (dn_local),
    .dn_write     (dn_write),
    .dn_rsp_valid (dn_rsp_valid),
    .dn_rsp_err   (dn_rsp_err),
    .erd          (erd),
    .bst          (bst),
    .badr         (badr),
    .pst          (pst),
    .padr         (padr)
);

// File: tb/sim_cfgb_bank.sv
`timescale 1ns/1ps
module sim_cfgb_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        dn_req, dn_local, dn_write;
    logic [31:0] dn_addr, dn_wdata;
    logic [3:0]  dn_be, dn_cmd;
    logic        dn_rsp_valid = 1'b0, dn_rsp_err = 1'b0;
    logic [31:0] dn_rsp_data = '0;

    always #5 clk = ~clk;

    cfgb_bank #(.ADDR_W(8)) u0 (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .dn_req(dn_req), .dn_local(dn_local),
        .dn_write(dn_write), .dn_addr(dn_addr), .dn_be(dn_be), .dn_cmd(dn_cmd),
        .dn_wdata(dn_wdata), .dn_rsp_valid(dn_rsp_valid),
        .dn_rsp_data(dn_rsp_data), .dn_rsp_err(dn_rsp_err)
    );

    int nchk = 0, nfail = 0;

    // downstream responder
    int          rsp_lat = 1;
    logic [31:0] rsp_dat = '0;
    logic        rsp_err = 1'b0;
    int          req_cnt = 0, pend = 0;
    logic        cap_loc, cap_wr;
    logic [31:0] cap_addr, cap_wd;
    logic [3:0]  cap_be, cap_cmd;

    always @(negedge clk) begin
        dn_rsp_valid = 1'b0;
        dn_rsp_err   = 1'b0;
        if (dn_req) begin
            req_cnt++;
            cap_loc = dn_local; cap_wr = dn_write; cap_addr = dn_addr;
            cap_be = dn_be; cap_cmd = dn_cmd; cap_wd = dn_wdata;
            pend = rsp_lat;
        end else if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                dn_rsp_valid = 1'b1;
                dn_rsp_data  = rsp_dat;
                dn_rsp_err   = rsp_err;
            end
        end
    end

    // register model
    logic [31:0] m_lctl = '0, m_lwd = '0, m_lrd = '0, m_eadr = '0;
    logic [31:0] m_ectl = '0, m_ewd = '0, m_erd = '0, m_badr = '0, m_padr = '0;
    logic [1:0]  m_bst = '0;
    logic        m_pst = 1'b0;

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00: return m_lctl;
            8'h04: return m_lwd;
            8'h08: return m_lrd;
            8'h0C: return m_eadr;
            8'h10: return m_ectl;
            8'h14: return m_ewd;
            8'h18: return m_erd;
            8'h1C: return {30'b0, m_bst};
            8'h20: return m_badr;
            8'h24: return {31'b0, m_pst};
            8'h28: return m_padr;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_for(input logic [7:0] a);
        case (a)
            8'h00: return "R2";
            8'h0C, 8'h10: return "R3";
            8'h04, 8'h08, 8'h14, 8'h18: return "R8";
            8'h1C, 8'h20: return "R9";
            8'h24, 8'h28: return "R10";
            default: return "R13";
        endcase
    endfunction

    task automatic mirror_write(input logic [7:0] a, input logic [31:0] wd);
        case (a)
            8'h00: m_lctl = wd & 32'h00F1_00FC;
            8'h04: m_lwd  = wd;
            8'h0C: m_eadr = wd;
            8'h10: m_ectl = wd & 32'h0000_00FF;
            8'h14: m_ewd  = wd;
            8'h1C: m_bst  = m_bst & ~wd[1:0];
            8'h24: m_pst  = m_pst & ~wd[0];
            default: ;
        endcase
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_op(input logic we, input logic [7:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output int waits);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
        waits = 0;
        #1;
        while (!bus_ready) begin
            @(negedge clk); #1;
            waits++;
        end
        rd = bus_rdata;
        @(posedge clk); #1;
        bus_valid = 1'b0;
    endtask

    task automatic access(input logic we, input logic [7:0] a, input logic [31:0] wd);
        logic [31:0] rd, exp_addr;
        logic        trig, loc;
        int          waits, prev;
        string       t;
        loc  = (a == 8'h04 || a == 8'h08);
        trig = (we && a == 8'h04 && m_lctl[16]) || (!we && a == 8'h08 && !m_lctl[16]) ||
               (we && a == 8'h14 && m_ectl[3:0] == 4'hB) || (!we && a == 8'h18 && m_ectl[3:0] == 4'hA);
        prev = req_cnt;
        bus_op(we, a, wd, rd, waits);
        if (trig) begin
            t = loc ? (we ? "R4" : "R5") : (we ? "R6" : "R7");
            exp_addr = loc ? (m_lctl & 32'hFC) : m_eadr;
            chk(t, 32'(req_cnt - prev), 32'd1);
            chk(t, {31'b0, cap_loc}, {31'b0, loc});
            chk(t, {31'b0, cap_wr}, {31'b0, we});
            chk(t, cap_addr, exp_addr);
            chk(t, {28'b0, cap_be}, loc ? {28'b0, m_lctl[23:20]} : {28'b0, m_ectl[7:4]});
            chk(t, {28'b0, cap_cmd}, loc ? 32'h0 : {28'b0, m_ectl[3:0]});
            if (we) chk(t, cap_wd, wd);
            chk("R14", 32'(waits), 32'(rsp_lat + 2));
            if (we) mirror_write(a, wd);
            if (rsp_err) begin
                if (loc) begin
                    if (!m_pst) m_padr = exp_addr;
                    m_pst = 1'b1;
                end else begin
                    if (m_bst == 2'b00) m_badr = exp_addr;
                    m_bst = m_bst | (we ? 2'b10 : 2'b01);
                end
            end
            if (!we) begin
                if (loc) m_lrd = rsp_dat;
                else     m_erd = rsp_err ? 32'hFFFF_FFFF : rsp_dat;
                chk(t, rd, loc ? m_lrd : m_erd);
            end
        end else begin
            chk("R8", 32'(req_cnt - prev), 32'd0);
            chk("R14", 32'(waits), 32'd0);
            if (!we) chk(tag_for(a), rd, exp_read(a));
            else     mirror_write(a, wd);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] rd;
        int w;
        bus_op(1'b0, a, 32'h0, rd, w);
        chk(tag, rd, exp);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state
        chk("R1", {31'b0, dn_req}, 32'h0);
        chk("R1", {31'b0, bus_ready}, 32'h0);
        for (int a = 0; a <= 'h28; a += 4)
            if (a != 8) rd_chk("R1", 8'(a), 32'h0);
        chk("R1", 32'(req_cnt), 32'h0);

        // R2, R3 field masks
        access(1'b1, 8'h00, 32'hFFFF_FFFF);
        rd_chk("R2", 8'h00, 32'h00F1_00FC);
        access(1'b1, 8'h10, 32'hFFFF_FFFF);
        rd_chk("R3", 8'h10, 32'h0000_00FF);
        access(1'b1, 8'h0C, 32'hDEAD_BEEF);
        rd_chk("R3", 8'h0C, 32'hDEAD_BEEF);

        // R13 unmapped, unaligned, read-only
        access(1'b1, 8'h2C, 32'h1234_5678);
        access(1'b1, 8'h02, 32'h1234_5678);
        access(1'b1, 8'h20, 32'h1234_5678);
        access(1'b1, 8'h18, 32'h1234_5678);
        rd_chk("R13", 8'h2C, 32'h0);
        rd_chk("R13", 8'h02, 32'h0);
        rd_chk("R13", 8'h20, 32'h0);
        rd_chk("R13", 8'h18, 32'h0);

        // R4 local write, R10 local error capture
        rsp_lat = 2; rsp_err = 1'b0;
        access(1'b1, 8'h00, 32'h0031_003C);
        access(1'b1, 8'h04, 32'hCAFE_0001);
        rsp_err = 1'b1;
        access(1'b1, 8'h04, 32'hCAFE_0002);
        rd_chk("R10", 8'h24, 32'h1);
        rd_chk("R10", 8'h28, 32'h3C);

        // R5 local read; R12 local address held while status set
        rsp_err = 1'b0; rsp_dat = 32'h0BAD_F00D;
        access(1'b1, 8'h00, 32'h00A0_0010);
        access(1'b0, 8'h08, 32'h0);
        rsp_err = 1'b1;
        access(1'b0, 8'h08, 32'h0);
        rd_chk("R12", 8'h28, 32'h3C);
        bus_op(1'b1, 8'h24, 32'h1, r, pend);  // W1C
        mirror_write(8'h24, 32'h1);
        rd_chk("R11", 8'h24, 32'h0);

        // R6 external write with error, R7 external read with error, R9, R12
        rsp_err = 1'b1; rsp_lat = 1;
        access(1'b1, 8'h0C, 32'h0001_0801);
        access(1'b1, 8'h10, 32'h0000_00FB);
        access(1'b1, 8'h14, 32'h5555_AAAA);
        rd_chk("R9", 8'h1C, 32'h2);
        access(1'b1, 8'h0C, 32'h0000_0104);
        access(1'b1, 8'h10, 32'h0000_003A);
        access(1'b0, 8'h18, 32'h0);
        rd_chk("R7", 8'h18, 32'hFFFF_FFFF);
        rd_chk("R12", 8'h1C, 32'h3);
        rd_chk("R12", 8'h20, 32'h0001_0801);
        // R11 write back read value clears exactly, zero bits leave
        bus_op(1'b1, 8'h1C, 32'h1, r, pend);
        mirror_write(8'h1C, 32'h1);
        rd_chk("R11", 8'h1C, 32'h2);
        bus_op(1'b1, 8'h1C, 32'h2, r, pend);
        mirror_write(8'h1C, 32'h2);
        rd_chk("R11", 8'h1C, 32'h0);

        // R8 mismatched command: no request
        access(1'b1, 8'h10, 32'h0000_0005);
        access(1'b1, 8'h14, 32'h7777_0000);
        access(1'b0, 8'h18, 32'h0);
        rd_chk("R8", 8'h14, 32'h7777_0000);

        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] v;
            v = $urandom;
            rsp_lat = 1 + int'($urandom % 4);
            rsp_dat = $urandom;
            rsp_err = ($urandom % 4) == 0;
            case ($urandom % 9)
                0: access(1'b1, 8'h00, v);
                1: begin
                    case ($urandom % 3)
                        0: v[3:0] = 4'hA;
                        1: v[3:0] = 4'hB;
                        default: ;
                    endcase
                    access(1'b1, 8'h10, v);
                end
                2: access(1'b1, 8'h0C, v);
                3: access(1'b1, 8'h04, v);
                4: access(1'b0, 8'h08, 32'h0);
                5: access(1'b1, 8'h14, v);
                6: access(1'b0, 8'h18, 32'h0);
                7: access(1'b0, 8'(4 * ($urandom % 12)), 32'h0);
                default: access($urandom % 2 == 0, 8'($urandom % 64), v);
            endcase
        end
        for (int a = 0; a <= 'h30; a += 4)
            access(1'b0, 8'(a), 32'h0);

        finish_run();
    end

endmodule